// File: doc/BRIEF.md
# Edge-Sensitive External Interrupt Controller

This block turns edges on eight external port pins into latched interrupt requests. It then arbitrates those requests against a set of peripheral interrupt flags for a small 8-bit CPU. The pins form two groups of four. Within each group, two pins respond to rising edges and two respond to falling edges. The pins of a group share one latched flag and one vector. Each pin is first synchronised to the CPU clock. It is then gated by its own enable bit, and the pins of the second group can also be switched to analog mode, which removes them from the interrupt logic.

The CPU sees a single request line and the index of the vector to serve. The request is held low while the CPU mask bit is set, but pending flags stay latched and are served once the mask clears. The CPU acknowledges the selected external vector on entry to its service routine. Software can also discard a pending external request with a per-group clear strobe. Fetching the vector and saving context on the stack are handled outside this block.

Top module: `xint_ctrl`

## Requirements
- R1: After reset, `ext_pend_o` is 0, `irq_o` is low and `vec_o` is 0.
- R2: Pins 0, 1, 4 and 5 are rising-type. If one of them goes low to high before clock edge n, the flag of its group is set and visible after edge n+2. Pins 0..3 form group 0 (flag bit 0) and pins 4..7 form group 1 (flag bit 1).
- R3: Pins 2, 3, 6 and 7 are falling-type and set their group flag on a high-to-low change, with the same latency as in R2. The opposite transition on any pin sets nothing.
- R4: A pin whose `pin_en_i` bit is 0 never sets a flag.
- R5: An edge that arrives while `cpu_mask_i` is high is latched, and `irq_o` rises as soon as the mask is low.
- R6: `vec_o` gives the lowest-numbered active request. Index 0 and index 1 are groups 0 and 1, and index 2+k is peripheral k. Lower indices win.
- R7: The enabled pins of a group are ORed in their active sense (high for rising-type, low for falling-type). A pin held active hides the edges of its partners.
- R8: When bit k of `pin_analog_i` is 1, pin 4+k cannot set a flag.
- R9: A pending flag stays set until it is cleared. A pulse on `ext_clr_i[g]` clears flag g and discards its request. An edge that lands in the same cycle as the clear wins, and the flag stays set.
- R10: If `ack_i` is high while `irq_o` is high and `vec_o` selects a group, that group's flag is cleared. A new edge in the same cycle wins.
- R11: Peripheral k requests at index 2+k while `per_flag_i[k]` and `per_en_i[k]` are both 1. Its request is not latched by this block.
- R12: `irq_o` is low whenever `cpu_mask_i` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | 8 | Raw external pin levels |
| pin_en_i | input | 8 | Per-pin interrupt enable |
| pin_analog_i | input | 4 | Analog-mode flags for pins 4..7 |
| cpu_mask_i | input | 1 | CPU interrupt mask bit |
| per_flag_i | input | 4 | Peripheral interrupt flags |
| per_en_i | input | 4 | Peripheral interrupt enables |
| ext_clr_i | input | 2 | Per-group clear strobe (software writes 0) |
| ack_i | input | 1 | Service-entry acknowledge for the selected vector |
| irq_o | output | 1 | Interrupt request to the CPU |
| vec_o | output | 3 | Index of the vector to serve |
| ext_pend_o | output | 2 | Latched external group flags |

## Verification
Two functions can fall in the same cycle, and the bench targets both collisions. The first is a new edge setting a group flag in the cycle that a clear strobe removes it. The second is a new edge arriving in the cycle that an acknowledge removes the flag. The bench provokes the first by raising the clear strobe exactly two cycles after driving the pin edge, so that it lands on the clock edge where the synchronised edge reaches the flag. It then requires the flag to survive. A behavioural model that applies "set beats clear" judges every cycle, and it compares the request line, the vector index and the flags against the design.

// File: rtl/xint_pkg.sv
package xint_pkg;
   typedef enum logic {PIN_FALL = 1'b0, PIN_RISE = 1'b1} pin_kind_e;

   // Inactive level of a pin: low for rising-type, high for falling-type.
   function automatic logic idle_level(input pin_kind_e kind);
      return (kind == PIN_RISE) ? 1'b0 : 1'b1;
   endfunction
endpackage

// File: rtl/xint_sync.sv
module xint_sync #(
   parameter int unsigned     N       = 8,
   parameter logic [N-1:0]    RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] d_i,
   output logic [N-1:0] q_o
);
   generate
      for (genvar i = 0; i < N; i++) begin : g_bit
         logic meta_q, stab_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               meta_q <= RST_VAL[i];
               stab_q <= RST_VAL[i];
            end else begin
               meta_q <= d_i[i];
               stab_q <= meta_q;
            end
         end
         assign q_o[i] = stab_q;
      end
   endgenerate
endmodule

// File: rtl/xint_group.sv
module xint_group #(
   parameter int unsigned        GS        = 4,
   parameter logic [GS-1:0]      RISE_MASK = 4'b0011
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [GS-1:0] lvl_i,
   input  logic [GS-1:0] gate_i,
   input  logic          clr_i,
   input  logic          ack_i,
   output logic          pend_o
);
   logic [GS-1:0] active;
   logic          line, line_q, edge_hit;

   // Active sense per pin: level for rising-type, inverted level for falling-type.
   assign active   = ~(lvl_i ^ RISE_MASK);
   assign line     = |(active & gate_i);
   assign edge_hit = line & ~line_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         line_q <= 1'b0;
         pend_o <= 1'b0;
      end else begin
         line_q <= line;
         if (edge_hit)            pend_o <= 1'b1;
         else if (clr_i || ack_i) pend_o <= 1'b0;
      end
   end
endmodule

// File: rtl/xint_prio.sv
module xint_prio #(
   parameter int unsigned N  = 6,
   parameter int unsigned VW = 3
) (
   input  logic [N-1:0]  req_i,
   output logic          any_o,
   output logic [VW-1:0] idx_o
);
   always_comb begin
      any_o = |req_i;
      idx_o = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (req_i[i]) idx_o = VW'(i);
      end
   end
endmodule

// File: rtl/xint_ctrl.sv
module xint_ctrl
   import xint_pkg::*;
#(
   parameter int unsigned       N_PIN     = 8,
   parameter int unsigned       GRP_SIZE  = 4,
   parameter int unsigned       N_PER     = 4,
   parameter logic [N_PIN-1:0]  RISE_MASK = 8'h33,
   parameter int unsigned       ANA_GRP   = 1,
   localparam int unsigned      N_GRP     = N_PIN / GRP_SIZE,
   localparam int unsigned      N_VEC     = N_GRP + N_PER,
   localparam int unsigned      VW        = (N_VEC > 1) ? $clog2(N_VEC) : 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [N_PIN-1:0]    pin_i,
   input  logic [N_PIN-1:0]    pin_en_i,
   input  logic [GRP_SIZE-1:0] pin_analog_i,
   input  logic                cpu_mask_i,
   input  logic [N_PER-1:0]    per_flag_i,
   input  logic [N_PER-1:0]    per_en_i,
   input  logic [N_GRP-1:0]    ext_clr_i,
   input  logic                ack_i,
   output logic                irq_o,
   output logic [VW-1:0]       vec_o,
   output logic [N_GRP-1:0]    ext_pend_o
);
   if (N_PIN % GRP_SIZE != 0) begin : g_bad_group
      $error("N_PIN must be a multiple of GRP_SIZE");
   end
   if (ANA_GRP >= N_GRP) begin : g_bad_ana
      $error("ANA_GRP out of range");
   end
   if (N_PER == 0) begin : g_bad_per
      $error("N_PER must be at least 1");
   end

   localparam logic [N_PIN-1:0] SYNC_RST = ~RISE_MASK;

   logic [N_PIN-1:0] pin_s;
   logic [N_VEC-1:0] req;
   logic             any_req;

   xint_sync #(.N(N_PIN), .RST_VAL(SYNC_RST)) u_sync (
      .clk(clk), .rst_n(rst_n), .d_i(pin_i), .q_o(pin_s)
   );

   generate
      for (genvar g = 0; g < N_GRP; g++) begin : g_grp
         logic [GRP_SIZE-1:0] gate;
         logic                ack_hit;
         if (g == ANA_GRP) begin : g_ana
            assign gate = pin_en_i[g*GRP_SIZE +: GRP_SIZE] & ~pin_analog_i;
         end else begin : g_dig
            assign gate = pin_en_i[g*GRP_SIZE +: GRP_SIZE];
         end
         assign ack_hit = ack_i & irq_o & (vec_o == VW'(g));
         xint_group #(
            .GS(GRP_SIZE), .RISE_MASK(RISE_MASK[g*GRP_SIZE +: GRP_SIZE])
         ) u_grp (
            .clk(clk), .rst_n(rst_n),
            .lvl_i(pin_s[g*GRP_SIZE +: GRP_SIZE]),
            .gate_i(gate),
            .clr_i(ext_clr_i[g]),
            .ack_i(ack_hit),
            .pend_o(ext_pend_o[g])
         );
      end
   endgenerate

   assign req = {per_flag_i & per_en_i, ext_pend_o};

   xint_prio #(.N(N_VEC), .VW(VW)) u_prio (
      .req_i(req), .any_o(any_req), .idx_o(vec_o)
   );

   assign irq_o = any_req & ~cpu_mask_i;
endmodule

// File: rtl/xint_ctrl_chk.sv
module xint_ctrl_chk #(
   parameter int unsigned N_GRP = 2,
   parameter int unsigned N_PER = 4,
   parameter int unsigned VW    = 3
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cpu_mask_i,
   input logic [N_PER-1:0] per_flag_i,
   input logic [N_PER-1:0] per_en_i,
   input logic [N_GRP-1:0] ext_clr_i,
   input logic             ack_i,
   input logic             irq_o,
   input logic [VW-1:0]    vec_o,
   input logic [N_GRP-1:0] ext_pend_o
);
   localparam int unsigned NV = N_GRP + N_PER;
   logic [NV-1:0] req, below;

   assign req   = {per_flag_i & per_en_i, ext_pend_o};
   assign below = req & ((NV'(1) << vec_o) - NV'(1));

   a_r12_mask_blocks: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_mask_i |-> !irq_o);

   a_r5_unmasked_serves: assert property (@(posedge clk) disable iff (!rst_n)
      ((|req) && !cpu_mask_i) |-> irq_o);

   a_r6_lowest_wins: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> (req[vec_o] && (below == '0)));

   generate
      for (genvar g = 0; g < N_GRP; g++) begin : g_hold
         a_r9_pend_held: assert property (@(posedge clk) disable iff (!rst_n)
            (ext_pend_o[g] && !ext_clr_i[g] && !(ack_i && irq_o && vec_o == VW'(g)))
            |=> ext_pend_o[g]);
      end
   endgenerate
endmodule

bind xint_ctrl xint_ctrl_chk #(.N_GRP(N_GRP), .N_PER(N_PER), .VW(VW)) u_chk (
   .clk(clk), .rst_n(rst_n), .cpu_mask_i(cpu_mask_i), .per_flag_i(per_flag_i),
   .per_en_i(per_en_i), .ext_clr_i(ext_clr_i), .ack_i(ack_i), .irq_o(irq_o),
   .vec_o(vec_o), .ext_pend_o(ext_pend_o)
);

// File: tb/xint_ctrl_bench.sv
module xint_ctrl_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] pin = 8'hCC, pin_en = 8'hFF;
   logic [3:0] ana = 4'h0, pflag = 4'h0, pen = 4'h0;
   logic       mask = 1'b0, ack = 1'b0;
   logic [1:0] clr = 2'b00;
   logic       irq_o;
   logic [2:0] vec_o;
   logic [1:0] ext_pend_o;

   int n_chk = 0, n_fail = 0, cyc = 0;
   string cur_req = "R1";

   always #2.5 clk = ~clk;

   xint_ctrl u_xint_ctrl (
      .clk(clk), .rst_n(rst_n), .pin_i(pin), .pin_en_i(pin_en), .pin_analog_i(ana),
      .cpu_mask_i(mask), .per_flag_i(pflag), .per_en_i(pen), .ext_clr_i(clr),
      .ack_i(ack), .irq_o(irq_o), .vec_o(vec_o), .ext_pend_o(ext_pend_o)
   );

   // Behavioural reference: pin history, group active lines, latched flags.
   logic [7:0] h1, h2;
   logic [1:0] m_prev, m_pend;
   logic       e_irq;
   logic [2:0] e_vec;

   function automatic logic pin_active(input logic lvl, input int p);
      // rising-type pins: 0,1,4,5 ; falling-type pins: 2,3,6,7
      return ((p % 4) < 2) ? lvl : !lvl;
   endfunction

   always_comb begin
      logic [5:0] r;
      r = {pflag & pen, m_pend};
      e_vec = 3'd0;
      for (int i = 5; i >= 0; i--) if (r[i]) e_vec = 3'(i);
      e_irq = (|r) && !mask;
   end

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         h1 = 8'hCC; h2 = 8'hCC; m_prev = 2'b00; m_pend = 2'b00;
      end else begin
         logic [1:0] line, nxt;
         for (int g = 0; g < 2; g++) begin
            line[g] = 1'b0;
            for (int k = 0; k < 4; k++) begin
               int p;
               p = g * 4 + k;
               if (pin_en[p] && !(g == 1 && ana[k]) && pin_active(h2[p], p))
                  line[g] = 1'b1;
            end
            if (line[g] && !m_prev[g]) nxt[g] = 1'b1;
            else if (clr[g] || (ack && e_irq && e_vec == 3'(g))) nxt[g] = 1'b0;
            else nxt[g] = m_pend[g];
         end
         m_pend = nxt; m_prev = line; h2 = h1; h1 = pin;
      end
   end

   task automatic check(input logic [7:0] act, input logic [7:0] exp, input string what);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", cur_req, what, act, exp);
      end
   endtask

   task automatic step(input int n = 1);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         #0.5;
         check(8'(irq_o), 8'(e_irq), "irq vs model");
         check(8'(vec_o), 8'(e_vec), "vec vs model");
         check(8'(ext_pend_o), 8'(m_pend), "pend vs model");
      end
   endtask

   task automatic clear_all();
      @(negedge clk); clr = 2'b11;
      @(negedge clk); clr = 2'b00;
      step(1);
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 20000) begin
         n_fail++;
         $display("FAIL watchdog: actual %0d expected < 20000 cycles", cyc);
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      cur_req = "R1"; step(2);
      check(8'(ext_pend_o), 8'h0, "reset pend");
      check(8'(irq_o), 8'h0, "reset irq");
      check(8'(vec_o), 8'h0, "reset vec");

      // R2 rising pin 0 -> group 0; flag after third edge
      cur_req = "R2";
      @(negedge clk); pin[0] = 1'b1;
      step(2); check(8'(ext_pend_o), 8'h0, "not yet set");
      step(1); check(8'(ext_pend_o), 8'h1, "pin0 rise sets group0");
      check(8'(vec_o), 8'h0, "vec group0");
      clear_all();
      // R3 falling pin 6 -> group 1
      cur_req = "R3";
      @(negedge clk); pin[6] = 1'b0;
      step(4); check(8'(ext_pend_o), 8'h2, "pin6 fall sets group1");
      check(8'(vec_o), 8'h1, "vec group1");
      clear_all();
      @(negedge clk); pin[6] = 1'b1; pin[0] = 1'b0;
      step(5); check(8'(ext_pend_o), 8'h0, "wrong-direction edges ignored");

      // R4 disabled pin
      cur_req = "R4";
      @(negedge clk); pin_en[1] = 1'b0;
      @(negedge clk); pin[1] = 1'b1;
      step(5); check(8'(ext_pend_o), 8'h0, "disabled pin1");
      @(negedge clk); pin[1] = 1'b0;
      step(4); @(negedge clk); pin_en[1] = 1'b1;
      step(3);

      // R7 pin held active hides partner
      cur_req = "R7";
      @(negedge clk); pin[0] = 1'b1;
      step(4); clear_all();
      @(negedge clk); pin[1] = 1'b1;
      step(5); check(8'(ext_pend_o), 8'h0, "pin1 hidden by pin0");
      @(negedge clk); pin[0] = 1'b0; pin[1] = 1'b0;
      step(4);
      @(negedge clk); pin[3] = 1'b0;
      step(4); check(8'(ext_pend_o), 8'h1, "pin3 fall after release");
      clear_all();
      @(negedge clk); pin[3] = 1'b1; step(4);

      // R8 analog mode on pin 6
      cur_req = "R8";
      @(negedge clk); ana[2] = 1'b1;
      @(negedge clk); pin[6] = 1'b0;
      step(5); check(8'(ext_pend_o), 8'h0, "analog pin6 ignored");
      @(negedge clk); pin[6] = 1'b1; step(4);
      @(negedge clk); ana[2] = 1'b0; step(2);

      // R12 masked, R5 latched then served
      cur_req = "R12";
      @(negedge clk); mask = 1'b1; pin[4] = 1'b1;
      step(5); check(8'(ext_pend_o), 8'h2, "latched while masked");
      check(8'(irq_o), 8'h0, "irq low under mask");
      cur_req = "R5";
      @(negedge clk); mask = 1'b0; #0.5;
      check(8'(irq_o), 8'h1, "served after unmask");
      check(8'(vec_o), 8'h1, "vec group1 after unmask");
      step(1);

      // R6 priority
      cur_req = "R6";
      @(negedge clk); pin[0] = 1'b1;
      step(4); check(8'(ext_pend_o), 8'h3, "both pending");
      check(8'(vec_o), 8'h0, "group0 wins");
      // R10 acknowledge clears selected flag
      cur_req = "R10";
      @(negedge clk); ack = 1'b1;
      @(negedge clk); ack = 1'b0; #0.5;
      check(8'(ext_pend_o), 8'h2, "ack cleared group0");
      check(8'(vec_o), 8'h1, "next vec group1");
      @(negedge clk); ack = 1'b1;
      @(negedge clk); ack = 1'b0; #0.5;
      check(8'(ext_pend_o), 8'h0, "ack cleared group1");
      @(negedge clk); pin[0] = 1'b0; pin[4] = 1'b0; step(4);
      // R10 edge and ack in same cycle: set wins
      @(negedge clk); pin[5] = 1'b1;
      step(3); // flag set
      @(negedge clk); pin[5] = 1'b0; step(3);
      @(negedge clk); pin[5] = 1'b1; step(1);
      @(negedge clk); ack = 1'b1;
      @(negedge clk); ack = 1'b0; #0.5;
      check(8'(ext_pend_o), 8'h2, "edge beats ack");
      clear_all();
      @(negedge clk); pin[5] = 1'b0; step(4);

      // R9 clear discards; edge beats clear in same cycle
      cur_req = "R9";
      @(negedge clk); pin[1] = 1'b1;
      step(1);
      @(negedge clk); clr = 2'b01;
      @(negedge clk); clr = 2'b00; #0.5;
      check(8'(ext_pend_o), 8'h1, "edge beats clear");
      step(6); check(8'(ext_pend_o), 8'h1, "flag held");
      @(negedge clk); clr = 2'b01;
      @(negedge clk); clr = 2'b00; #0.5;
      check(8'(ext_pend_o), 8'h0, "clear discards");
      check(8'(irq_o), 8'h0, "request lost");
      @(negedge clk); pin[1] = 1'b0; step(4);

      // R11 peripheral requests
      cur_req = "R11";
      @(negedge clk); pflag = 4'b0010; pen = 4'b0000; #0.5;
      check(8'(irq_o), 8'h0, "peripheral disabled");
      @(negedge clk); pen = 4'b1010; #0.5;
      check(8'(irq_o), 8'h1, "peripheral irq");
      check(8'(vec_o), 8'h3, "peripheral 1 index 3");
      @(negedge clk); pflag = 4'b1010; #0.5;
      check(8'(vec_o), 8'h3, "peripheral 1 beats 3");
      @(negedge clk); pflag = 4'b1000; #0.5;
      check(8'(vec_o), 8'h5, "peripheral 3 index 5");
      @(negedge clk); pflag = 4'b0000; #0.5;
      check(8'(irq_o), 8'h0, "no latching of peripheral");
      step(3);

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule